// File: doc/BRIEF.md
# Triggered Multi-Channel PWM Generator

A bank of pulse-width modulators sharing one register window of 32-bit words. Software writes 32-bit words at byte offsets. Each channel keeps shadow settings for prescale, period count, duty count and polarity. The waveform logic ignores these shadow settings until software commits them by raising that channel's trigger bit.

At the rising edge of the trigger, the shadow settings are captured into a staging copy. The staging copy becomes active in one of two ways:

- after a fixed, parameterised latency (immediate mode), or
- at the next period wrap (smooth mode).

The per-channel smooth bit chooses the mode. There is no enable bit. A zero duty count gives the idle level. A channel whose trigger and smooth bits are both clear drives a constant high.

The count clock of each channel is the system clock divided by prescale+1. Within a period, the output is active while the period counter is below the committed duty count.

Top module: `pwm_trig_bank`

## Requirements
- R1: Register map. Offset 0x00 holds the control word: trigger in bit c, polarity in bit 8+c, output type in bit 16+c, smooth in bit 24+c. Offset 0x04 holds the 3-bit prescale of channel c at bit 4*c. The period count of channel c is at 0x08+8*c and its duty count at 0x0C+8*c, both 24 bits. Unused bits read as zero, and unmapped offsets read as zero. A read returns data in the same cycle as the request.
- R2: After reset, every register reads zero and every output is high.
- R3: Writes to prescale, period, duty and polarity have no effect on the output until that channel's trigger bit goes from 0 to 1 in a control write.
- R4: With smooth clear at the trigger rise, the new settings drive the output from the clock edge IMM_DELAY+1 edges after the edge that accepted the control write. The prescale and period counters restart from zero at that edge.
- R5: With smooth set at the trigger rise, the new settings take effect at the first period wrap after the rise is registered, with both counters restarting from zero.
- R6: The period counter advances once every prescale+1 clocks and wraps after period-count steps.
- R7: A committed polarity of 1 makes the output high while the counter is below the duty count. A committed polarity of 0 inverts the output.
- R8: A duty count of zero holds the output inactive for the whole period. A duty count at or above a nonzero period count holds it active.
- R9: While a channel's trigger and smooth bits are both clear, its output is high. When either bit is set, the committed waveform continues.
- R10: The output-type bits are stored and read back but do not change any output.
- R11: The values captured at the trigger rise are the ones committed. Shadow writes made while a commit is pending do not alter it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access valid strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid while req_i is high and we_i is low |
| pwm_o | output | N_CH (6) | One PWM line per channel |

## Verification
The assertions assume IMM_DELAY is at least 1. They also assume a trigger rise is produced only by a control write, so a rise pulse always has a write behind it in the previous cycle.

The bench drives accesses one at a time, always with an idle cycle between them. It uses only aligned offsets. It retriggers a channel only after first clearing its trigger bit, so every commit comes from a real 0-to-1 transition.

Periods and prescales are kept small so that every smooth commit reaches a period wrap within the observed window.

// File: rtl/pwm_trig_pkg.sv
package pwm_trig_pkg;
  localparam int unsigned ADDR_W       = 8;
  localparam logic [7:0]  OFS_CTRL     = 8'h00;
  localparam logic [7:0]  OFS_PRE      = 8'h04;
  localparam int unsigned OFS_CH_BASE  = 8;
  localparam int unsigned CH_STRIDE    = 8;
  localparam int unsigned OFS_DUTY_REL = 4;
  localparam int unsigned LANE_POL     = 8;
  localparam int unsigned LANE_TYPE    = 16;
  localparam int unsigned LANE_SMOOTH  = 24;
  localparam int unsigned PRE_SPAN     = 4;

  typedef enum logic [1:0] {
    CM_IDLE = 2'd0,
    CM_IMM  = 2'd1,
    CM_EDGE = 2'd2
  } commit_mode_e;
endpackage

// File: rtl/pwm_trig_regs.sv
module pwm_trig_regs
  import pwm_trig_pkg::*;
#(
  parameter int unsigned N_CH  = 6,
  parameter int unsigned CNT_W = 24,
  parameter int unsigned PRE_W = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_i,
  input  logic                        we_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [31:0]                 wdata_i,
  output logic [31:0]                 rdata_o,
  output logic [N_CH-1:0]             trig_o,
  output logic [N_CH-1:0]             smooth_o,
  output logic [N_CH-1:0]             pol_o,
  output logic [N_CH-1:0]             rise_o,
  output logic [N_CH-1:0][PRE_W-1:0]  pre_o,
  output logic [N_CH-1:0][CNT_W-1:0]  per_o,
  output logic [N_CH-1:0][CNT_W-1:0]  duty_o
);

  function automatic logic [ADDR_W-1:0] per_ofs(input int unsigned c);
    return ADDR_W'(OFS_CH_BASE + CH_STRIDE * c);
  endfunction

  function automatic logic [ADDR_W-1:0] duty_ofs(input int unsigned c);
    return ADDR_W'(OFS_CH_BASE + CH_STRIDE * c + OFS_DUTY_REL);
  endfunction

  logic                       wr;
  logic [N_CH-1:0]            trig_q, smooth_q, pol_q, type_q, rise_q;
  logic [N_CH-1:0][PRE_W-1:0] pre_q;
  logic [N_CH-1:0][CNT_W-1:0] per_q, duty_q;

  assign wr = req_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trig_q   <= '0;
      smooth_q <= '0;
      pol_q    <= '0;
      type_q   <= '0;
      rise_q   <= '0;
      pre_q    <= '0;
      per_q    <= '0;
      duty_q   <= '0;
    end else begin
      rise_q <= '0;
      if (wr && addr_i == OFS_CTRL) begin
        // edge detect against the previously stored trigger bits
        rise_q   <= wdata_i[N_CH-1:0] & ~trig_q;
        trig_q   <= wdata_i[N_CH-1:0];
        pol_q    <= wdata_i[LANE_POL +: N_CH];
        type_q   <= wdata_i[LANE_TYPE +: N_CH];
        smooth_q <= wdata_i[LANE_SMOOTH +: N_CH];
      end
      for (int unsigned c = 0; c < N_CH; c++) begin
        if (wr && addr_i == OFS_PRE)     pre_q[c]  <= wdata_i[PRE_SPAN*c +: PRE_W];
        if (wr && addr_i == per_ofs(c))  per_q[c]  <= wdata_i[CNT_W-1:0];
        if (wr && addr_i == duty_ofs(c)) duty_q[c] <= wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == OFS_CTRL) begin
        rdata_o[N_CH-1:0]           = trig_q;
        rdata_o[LANE_POL +: N_CH]    = pol_q;
        rdata_o[LANE_TYPE +: N_CH]   = type_q;
        rdata_o[LANE_SMOOTH +: N_CH] = smooth_q;
      end
      for (int unsigned c = 0; c < N_CH; c++) begin
        if (addr_i == OFS_PRE)     rdata_o[PRE_SPAN*c +: PRE_W] = pre_q[c];
        if (addr_i == per_ofs(c))  rdata_o[CNT_W-1:0]           = per_q[c];
        if (addr_i == duty_ofs(c)) rdata_o[CNT_W-1:0]           = duty_q[c];
      end
    end
  end

  assign trig_o   = trig_q;
  assign smooth_o = smooth_q;
  assign pol_o    = pol_q;
  assign rise_o   = rise_q;
  assign pre_o    = pre_q;
  assign per_o    = per_q;
  assign duty_o   = duty_q;

  AST_RISE_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|rise_q) |-> $past(req_i && we_i && addr_i == OFS_CTRL)); // R3

endmodule

// File: rtl/pwm_trig_chan.sv
module pwm_trig_chan
  import pwm_trig_pkg::*;
#(
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned PRE_W     = 3,
  parameter int unsigned IMM_DELAY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             smooth_i,
  input  logic             trig_i,
  input  logic             pol_i,
  input  logic [PRE_W-1:0] pre_i,
  input  logic [CNT_W-1:0] per_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             pwm_o
);

  localparam int unsigned DLY_W = $clog2(IMM_DELAY + 1);

  commit_mode_e     mode_q;
  logic [DLY_W-1:0] dly_q;
  logic [PRE_W-1:0] stg_pre_q, act_pre_q, pre_cnt_q;
  logic [CNT_W-1:0] stg_per_q, stg_duty_q, act_per_q, act_duty_q, cnt_q;
  logic             stg_pol_q, act_pol_q;
  logic             tick, wrap, apply, active;
  logic [CNT_W:0]   cnt_inc;

  assign tick    = (pre_cnt_q == act_pre_q);
  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign wrap    = (cnt_inc >= {1'b0, act_per_q});
  assign apply   = !rise_i &&
                   ((mode_q == CM_IMM && dly_q == DLY_W'(1)) ||
                    (mode_q == CM_EDGE && tick && wrap));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q     <= CM_IDLE;
      dly_q      <= '0;
      stg_pre_q  <= '0;
      stg_per_q  <= '0;
      stg_duty_q <= '0;
      stg_pol_q  <= 1'b0;
    end else if (rise_i) begin
      stg_pre_q  <= pre_i;
      stg_per_q  <= per_i;
      stg_duty_q <= duty_i;
      stg_pol_q  <= pol_i;
      mode_q     <= smooth_i ? CM_EDGE : CM_IMM;
      dly_q      <= DLY_W'(IMM_DELAY);
    end else if (apply) begin
      mode_q <= CM_IDLE;
      dly_q  <= '0;
    end else if (mode_q == CM_IMM) begin
      dly_q <= dly_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_pre_q  <= '0;
      act_per_q  <= '0;
      act_duty_q <= '0;
      act_pol_q  <= 1'b0;
      pre_cnt_q  <= '0;
      cnt_q      <= '0;
    end else if (apply) begin
      act_pre_q  <= stg_pre_q;
      act_per_q  <= stg_per_q;
      act_duty_q <= stg_duty_q;
      act_pol_q  <= stg_pol_q;
      pre_cnt_q  <= '0;
      cnt_q      <= '0;
    end else if (tick) begin
      pre_cnt_q <= '0;
      cnt_q     <= wrap ? '0 : cnt_inc[CNT_W-1:0];
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  assign active = (cnt_q < act_duty_q);
  assign pwm_o  = (!trig_i && !smooth_i) ? 1'b1 : (act_pol_q ? active : !active);

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_per_q != '0) |-> (cnt_q < act_per_q)); // R6
  AST_PRE_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt_q <= act_pre_q); // R6
  AST_DLY_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CM_IMM) |-> (dly_q >= DLY_W'(1) && dly_q <= DLY_W'(IMM_DELAY))); // R4
  AST_ACT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_duty_q) |-> ($past(mode_q) != CM_IDLE)); // R3
  AST_EDGE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == CM_EDGE && mode_q == CM_IDLE) |-> (cnt_q == '0 && pre_cnt_q == '0)); // R5

endmodule

// File: rtl/pwm_trig_bank.sv
module pwm_trig_bank
  import pwm_trig_pkg::*;
#(
  parameter int unsigned N_CH      = 6,
  parameter int unsigned CNT_W     = 24,
  parameter int unsigned PRE_W     = 3,
  parameter int unsigned IMM_DELAY = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  output logic [N_CH-1:0] pwm_o
);

  logic [N_CH-1:0]            trig, smooth, pol, rise;
  logic [N_CH-1:0][PRE_W-1:0] pre;
  logic [N_CH-1:0][CNT_W-1:0] per, duty;

  pwm_trig_regs #(
    .N_CH (N_CH),
    .CNT_W(CNT_W),
    .PRE_W(PRE_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .trig_o  (trig),
    .smooth_o(smooth),
    .pol_o   (pol),
    .rise_o  (rise),
    .pre_o   (pre),
    .per_o   (per),
    .duty_o  (duty)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    pwm_trig_chan #(
      .CNT_W    (CNT_W),
      .PRE_W    (PRE_W),
      .IMM_DELAY(IMM_DELAY)
    ) u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rise_i  (rise[c]),
      .smooth_i(smooth[c]),
      .trig_i  (trig[c]),
      .pol_i   (pol[c]),
      .pre_i   (pre[c]),
      .per_i   (per[c]),
      .duty_i  (duty[c]),
      .pwm_o   (pwm_o[c])
    );

    AST_FORCED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!trig[c] && !smooth[c]) |-> pwm_o[c]); // R9
  end

endmodule

// File: tb/tb_pwm_trig_bank.sv
`timescale 1ns/1ps
module tb_pwm_trig_bank;
  localparam int NCH = 6;
  localparam int DLY = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] pwm;

  int errors = 0, checks = 0;
  string cur_req = "R2";
  bit done = 0;

  always #2 clk = ~clk;

  pwm_trig_bank #(.N_CH(NCH), .IMM_DELAY(DLY)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pwm_o(pwm)
  );

  // behavioural reference model
  bit m_trig[NCH], m_pol[NCH], m_smooth[NCH], m_rise[NCH];
  int m_pre[NCH], m_per[NCH], m_duty[NCH];
  int s_pre[NCH], s_per[NCH], s_duty[NCH]; bit s_pol[NCH];
  int a_pre[NCH], a_per[NCH], a_duty[NCH]; bit a_pol[NCH];
  int mode[NCH], left[NCH], pc[NCH], cnt[NCH];

  task automatic model_reset();
    for (int c = 0; c < NCH; c++) begin
      m_trig[c] = 0; m_pol[c] = 0; m_smooth[c] = 0; m_rise[c] = 0;
      m_pre[c] = 0; m_per[c] = 0; m_duty[c] = 0;
      s_pre[c] = 0; s_per[c] = 0; s_duty[c] = 0; s_pol[c] = 0;
      a_pre[c] = 0; a_per[c] = 0; a_duty[c] = 0; a_pol[c] = 0;
      mode[c] = 0; left[c] = 0; pc[c] = 0; cnt[c] = 0;
    end
  endtask

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      bit tk, wr_, ap;
      tk = (pc[c] == a_pre[c]);
      wr_ = (cnt[c] + 1 >= a_per[c]);
      ap = 0;
      if (m_rise[c]) begin
        s_pre[c] = m_pre[c]; s_per[c] = m_per[c]; s_duty[c] = m_duty[c]; s_pol[c] = m_pol[c];
        mode[c] = m_smooth[c] ? 2 : 1; left[c] = DLY;
      end else if (mode[c] == 1) begin
        if (left[c] == 1) ap = 1; else left[c]--;
      end else if (mode[c] == 2 && tk && wr_) ap = 1;
      if (ap) begin
        a_pre[c] = s_pre[c]; a_per[c] = s_per[c]; a_duty[c] = s_duty[c]; a_pol[c] = s_pol[c];
        mode[c] = 0; left[c] = 0; pc[c] = 0; cnt[c] = 0;
      end else if (tk) begin
        pc[c] = 0; cnt[c] = wr_ ? 0 : cnt[c] + 1;
      end else pc[c]++;
    end
    for (int c = 0; c < NCH; c++) m_rise[c] = 0;
    if (req && we) begin
      if (addr == 8'h00) begin
        for (int c = 0; c < NCH; c++) begin
          m_rise[c] = wdata[c] && !m_trig[c];
          m_trig[c] = wdata[c]; m_pol[c] = wdata[8+c]; m_smooth[c] = wdata[24+c];
        end
      end else if (addr == 8'h04) begin
        for (int c = 0; c < NCH; c++) m_pre[c] = (wdata >> (4*c)) & 7;
      end else if (addr >= 8 && addr < 8 + 8*NCH) begin
        int c;
        c = (addr - 8) / 8;
        if (addr % 8 == 0) m_per[c] = wdata & 32'hFFFFFF;
        else if (addr % 8 == 4) m_duty[c] = wdata & 32'hFFFFFF;
      end
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else model_step();
  end

  function automatic logic [NCH-1:0] model_out();
    logic [NCH-1:0] o;
    for (int c = 0; c < NCH; c++) begin
      bit act;
      act = cnt[c] < a_duty[c];
      o[c] = (!m_trig[c] && !m_smooth[c]) ? 1'b1 : (a_pol[c] ? act : !act);
    end
    return o;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] e;
      e = model_out();
      checks++;
      if (pwm !== e) begin
        errors++;
        $display("FAIL %s pwm_o at %0t: got %b expected %b", cur_req, $time, pwm, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string r);
    @(negedge clk); req = 1; we = 0; addr = a;
    #1;
    checks++;
    if (rdata !== exp) begin
      errors++;
      $display("FAIL %s read 0x%02h: got 0x%08h expected 0x%08h", r, a, rdata, exp);
    end
    @(negedge clk); req = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] ctl = '0;

  initial begin
    idle(2);
    rst_n = 1;
    idle(2);
    // R2 reset state
    cur_req = "R2";
    rd(8'h00, 32'h0, "R2");
    rd(8'h08, 32'h0, "R2");
    rd(8'h04, 32'h0, "R2");
    // R1 map and masking
    cur_req = "R1";
    wr(8'h20, 32'hABCDEF12); rd(8'h20, 32'h00CDEF12, "R1");
    wr(8'h04, 32'hFFFFFFFF); rd(8'h04, 32'h00777777, "R1");
    wr(8'h34, 32'h00123456); rd(8'h34, 32'h00123456, "R1");
    rd(8'h40, 32'h0, "R1");
    wr(8'h00, 32'hFFFFFF00); rd(8'h00, 32'h3F3F3F00, "R1");
    wr(8'h00, 32'h0); wr(8'h20, 0); wr(8'h04, 0); wr(8'h34, 0);
    // R4 immediate commit on ch0, normal polarity
    cur_req = "R4";
    wr(8'h08, 5); wr(8'h0C, 2);
    ctl = 32'h0000_0101; wr(8'h00, ctl);
    idle(20);
    // R3 shadow write without trigger
    cur_req = "R3";
    wr(8'h0C, 4);
    idle(12);
    rd(8'h0C, 32'd4, "R3");
    // R5 / R11 smooth commit with a late shadow write
    cur_req = "R5/R11";
    ctl = 32'h0100_0100; wr(8'h00, ctl);
    ctl = 32'h0100_0101; wr(8'h00, ctl);
    wr(8'h0C, 1);
    idle(20);
    // R6 prescale on ch2
    cur_req = "R6";
    wr(8'h04, 32'h0000_0200); wr(8'h18, 4); wr(8'h1C, 1);
    ctl = ctl | 32'h0000_0404; wr(8'h00, ctl);
    idle(40);
    // R7 inverted polarity on ch1
    cur_req = "R7";
    wr(8'h10, 6); wr(8'h14, 2);
    ctl = ctl | 32'h0000_0002; wr(8'h00, ctl);
    idle(24);
    // R8 duty extremes on ch3 and ch4
    cur_req = "R8";
    wr(8'h20, 4); wr(8'h24, 9);
    wr(8'h28, 3); wr(8'h2C, 0);
    ctl = ctl | 32'h0000_1818; wr(8'h00, ctl);
    idle(20);
    // R9 trigger cleared with smooth kept, then both cleared
    cur_req = "R9";
    ctl = ctl & ~32'h1; wr(8'h00, ctl);
    idle(12);
    ctl = ctl & ~32'h0100_0000; wr(8'h00, ctl);
    idle(12);
    // R10 output-type bits
    cur_req = "R10";
    ctl = ctl | 32'h003F_0000; wr(8'h00, ctl);
    idle(20);
    rd(8'h00, ctl & 32'h3F3F3F3F, "R10");
    // R4 immediate recommit on ch2 mid-period
    cur_req = "R4";
    ctl = ctl & ~32'h4; wr(8'h00, ctl);
    wr(8'h04, 32'h0); wr(8'h18, 7); wr(8'h1C, 3);
    ctl = ctl | 32'h4; wr(8'h00, ctl);
    idle(30);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule